// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small eight-bit processor core. After an ALU operation it captures the condition flags for carry, zero, negative, overflow and half carry, so that a later conditional branch can test them without a separate compare. The sign flag is not stored. It is always formed as negative XOR overflow. The word also holds a global interrupt enable, which gates the interrupt request passed on to the core. It also holds a one-bit scratch store used to copy a bit from one register operand into a bit of another.

The core drives the block with per-flag ALU results and their update masks, with interrupt-accept, return, enable-set and enable-clear strobes, with bit-store and bit-load controls, and with a memory-mapped write port. Every stored bit changes on the rising clock edge after its stimulus. The gated interrupt request and the bit-load result are combinational. Taking an interrupt clears only the enable bit, and returning sets it again. The other flags are neither saved nor restored by hardware.

Top module: `cpu_flag_reg`

## Requirements
- R1: The status word sreg_o has the layout, from bit 7 down to bit 0: interrupt enable, copy store, half carry, sign, overflow, negative, zero, carry. Each bit also appears on its own flag port. All bits are 0 after reset.
- R2: A cycle with wr_en_i high loads bits 7, 6, 5, 3, 2, 1 and 0 of wr_data_i into the matching bits after the next edge. Bit 4 of wr_data_i has no effect.
- R3: The sign bit always equals negative XOR overflow, including right after a write or an ALU update of either flag.
- R4: alu_val_i and alu_upd_i are ordered bit 4 half carry, bit 3 overflow, bit 2 negative, bit 1 zero, bit 0 carry. A flag whose update bit is 1 takes the value bit after the next edge. A flag whose update bit is 0 keeps its value.
- R5: A direct write in the same cycle as an ALU update wins for every ALU flag.
- R6: irq_take_i clears the interrupt enable after the next edge. It takes priority over a write, a return and an enable-set in the same cycle.
- R7: ret_irq_i or ien_set_i sets the interrupt enable, and ien_clr_i clears it. Set or return wins over clear, and a direct write wins over all three.
- R8: irq_req_o equals irq_req_i while the interrupt enable is 1, and is 0 while it is 0, in the same cycle.
- R9: bit_store_i copies bit bit_sel_i of opnd_i into the copy store after the next edge. A direct write in the same cycle wins.
- R10: bld_o equals opnd_i with the bit at position bit_sel_i replaced by the copy store, combinationally.
- R11: Accepting an interrupt and returning from one leave every bit other than the interrupt enable unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_val_i | input | 5 | ALU flag results |
| alu_upd_i | input | 5 | Per-flag update mask |
| irq_take_i | input | 1 | Interrupt accepted strobe |
| ret_irq_i | input | 1 | Return-from-interrupt strobe |
| ien_set_i | input | 1 | Enable-set command |
| ien_clr_i | input | 1 | Enable-clear command |
| bit_store_i | input | 1 | Copy selected operand bit into copy store |
| bit_sel_i | input | SEL_W (3) | Bit position for store and load |
| opnd_i | input | OPND_W (8) | Register operand |
| bld_o | output | OPND_W (8) | Operand with selected bit replaced by copy store |
| wr_en_i | input | 1 | Direct write enable |
| wr_data_i | input | 8 | Direct write data |
| irq_req_i | input | 1 | Raw interrupt request |
| irq_req_o | output | 1 | Request gated by interrupt enable |
| sreg_o | output | 8 | Full status word |
| flg_ie_o | output | 1 | Interrupt enable |
| flg_cp_o | output | 1 | Copy store |
| flg_h_o | output | 1 | Half carry |
| flg_s_o | output | 1 | Sign |
| flg_v_o | output | 1 | Overflow |
| flg_n_o | output | 1 | Negative |
| flg_z_o | output | 1 | Zero |
| flg_c_o | output | 1 | Carry |

## Verification
Every stored bit passes through exactly one register, so an update is due one clock edge after its strobe. The sign bit is derived from stored flags and follows in that same cycle. Each scenario task drives its inputs just after a rising edge, lets one edge pass, and samples one time step later. The gated request and the bit-load result have no register in their path, so the tasks check them one time step after driving, with no edge in between. Same-cycle priority cases apply all competing strobes together for a single edge.

// File: rtl/cpu_flag_pkg.sv
package cpu_flag_pkg;
   localparam int unsigned SR_W   = 8;
   localparam int unsigned POS_IE = 7;
   localparam int unsigned POS_CP = 6;
   localparam int unsigned POS_H  = 5;
   localparam int unsigned POS_S  = 4;
   localparam int unsigned POS_V  = 3;
   localparam int unsigned POS_N  = 2;
   localparam int unsigned POS_Z  = 1;
   localparam int unsigned POS_C  = 0;

   localparam int unsigned ALU_W = 5;
   localparam int unsigned AF_C  = 0;
   localparam int unsigned AF_Z  = 1;
   localparam int unsigned AF_N  = 2;
   localparam int unsigned AF_V  = 3;
   localparam int unsigned AF_H  = 4;

   typedef logic [ALU_W-1:0] alu_vec_t;
endpackage

// File: rtl/flag_ie_ctl.sv
module flag_ie_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic wr_i,
   input  logic wr_bit_i,
   input  logic ret_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic req_i,
   output logic req_o,
   output logic ie_o
);
   logic ie_q, ie_d;

   always_comb begin
      ie_d = ie_q;
      if (take_i)              ie_d = 1'b0;
      else if (wr_i)           ie_d = wr_bit_i;
      else if (ret_i || set_i) ie_d = 1'b1;
      else if (clr_i)          ie_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ie_q <= 1'b0;
      else        ie_q <= ie_d;

   assign ie_o  = ie_q;
   assign req_o = req_i & ie_q;

   assert_take_clears_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> !ie_o);
   assert_ret_sets_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i || set_i) && !take_i && !wr_i |=> ie_o);
   assert_clr_drops_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !ret_i && !set_i && !wr_i |=> !ie_o);
endmodule

// File: rtl/flag_bit_copy.sv
module flag_bit_copy #(
   parameter int unsigned OPND_W = 8,
   localparam int unsigned SEL_W = $clog2(OPND_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              wr_bit_i,
   input  logic              store_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [OPND_W-1:0] opnd_i,
   output logic [OPND_W-1:0] load_o,
   output logic              cp_o
);
   logic cp_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cp_q <= 1'b0;
      else if (wr_i)    cp_q <= wr_bit_i;
      else if (store_i) cp_q <= opnd_i[sel_i];

   for (genvar b = 0; b < OPND_W; b++) begin : g_load
      assign load_o[b] = (sel_i == SEL_W'(b)) ? cp_q : opnd_i[b];
   end

   assign cp_o = cp_q;

   assert_store_copies_R9: assert property (@(posedge clk) disable iff (!rst_n)
      store_i && !wr_i |=> cp_o == $past(opnd_i[sel_i]));
   assert_write_over_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> cp_o == $past(wr_bit_i));
endmodule

// File: rtl/flag_alu_merge.sv
module flag_alu_merge
   import cpu_flag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_i,
   input  alu_vec_t wr_flags_i,
   input  alu_vec_t val_i,
   input  alu_vec_t upd_i,
   output alu_vec_t flags_o
);
   alu_vec_t q;

   for (genvar f = 0; f < ALU_W; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)        q[f] <= 1'b0;
         else if (wr_i)     q[f] <= wr_flags_i[f];
         else if (upd_i[f]) q[f] <= val_i[f];

      assert_masked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_i && !upd_i[f] |=> $stable(flags_o[f]));
      assert_masked_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_i && upd_i[f] |=> flags_o[f] == $past(val_i[f]));
   end

   assign flags_o = q;

   assert_write_over_alu_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> flags_o == $past(wr_flags_i));
endmodule

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
   import cpu_flag_pkg::*;
#(
   parameter int unsigned OPND_W = 8,
   localparam int unsigned SEL_W = $clog2(OPND_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        alu_val_i,
   input  logic [4:0]        alu_upd_i,
   input  logic              irq_take_i,
   input  logic              ret_irq_i,
   input  logic              ien_set_i,
   input  logic              ien_clr_i,
   input  logic              bit_store_i,
   input  logic [SEL_W-1:0]  bit_sel_i,
   input  logic [OPND_W-1:0] opnd_i,
   output logic [OPND_W-1:0] bld_o,
   input  logic              wr_en_i,
   input  logic [7:0]        wr_data_i,
   input  logic              irq_req_i,
   output logic              irq_req_o,
   output logic [7:0]        sreg_o,
   output logic              flg_ie_o,
   output logic              flg_cp_o,
   output logic              flg_h_o,
   output logic              flg_s_o,
   output logic              flg_v_o,
   output logic              flg_n_o,
   output logic              flg_z_o,
   output logic              flg_c_o
);
   initial begin
      assert (OPND_W >= 2 && (1 << SEL_W) == OPND_W)
         else $error("OPND_W must be a power of two, at least 2");
      assert (ALU_W == 5 && SR_W == 8)
         else $error("flag package widths do not match the status word");
   end

   logic     ie, cp;
   alu_vec_t alu_q, wr_alu;
   logic     unused_wr_sign;

   assign wr_alu[AF_H] = wr_data_i[POS_H];
   assign wr_alu[AF_V] = wr_data_i[POS_V];
   assign wr_alu[AF_N] = wr_data_i[POS_N];
   assign wr_alu[AF_Z] = wr_data_i[POS_Z];
   assign wr_alu[AF_C] = wr_data_i[POS_C];
   assign unused_wr_sign = wr_data_i[POS_S];

   flag_ie_ctl u_ie (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (irq_take_i),
      .wr_i     (wr_en_i),
      .wr_bit_i (wr_data_i[POS_IE]),
      .ret_i    (ret_irq_i),
      .set_i    (ien_set_i),
      .clr_i    (ien_clr_i),
      .req_i    (irq_req_i),
      .req_o    (irq_req_o),
      .ie_o     (ie)
   );

   flag_bit_copy #(.OPND_W(OPND_W)) u_copy (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_en_i),
      .wr_bit_i (wr_data_i[POS_CP]),
      .store_i  (bit_store_i),
      .sel_i    (bit_sel_i),
      .opnd_i   (opnd_i),
      .load_o   (bld_o),
      .cp_o     (cp)
   );

   flag_alu_merge u_alu (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_en_i),
      .wr_flags_i (wr_alu),
      .val_i      (alu_val_i),
      .upd_i      (alu_upd_i),
      .flags_o    (alu_q)
   );

   always_comb begin
      sreg_o         = '0;
      sreg_o[POS_IE] = ie;
      sreg_o[POS_CP] = cp;
      sreg_o[POS_H]  = alu_q[AF_H];
      sreg_o[POS_S]  = alu_q[AF_N] ^ alu_q[AF_V];
      sreg_o[POS_V]  = alu_q[AF_V];
      sreg_o[POS_N]  = alu_q[AF_N];
      sreg_o[POS_Z]  = alu_q[AF_Z];
      sreg_o[POS_C]  = alu_q[AF_C];
   end

   assign flg_ie_o = sreg_o[POS_IE];
   assign flg_cp_o = sreg_o[POS_CP];
   assign flg_h_o  = sreg_o[POS_H];
   assign flg_s_o  = sreg_o[POS_S];
   assign flg_v_o  = sreg_o[POS_V];
   assign flg_n_o  = sreg_o[POS_N];
   assign flg_z_o  = sreg_o[POS_Z];
   assign flg_c_o  = sreg_o[POS_C];

   assert_take_keeps_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take_i || ret_irq_i) && !wr_en_i && !bit_store_i && alu_upd_i == '0
      |=> $stable(sreg_o[6:0]));
   assert_write_loads_ie_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && !irq_take_i |=> flg_ie_o == $past(wr_data_i[POS_IE]));
endmodule

// File: tb/cpu_flag_reg_tb.sv
module cpu_flag_reg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] alu_val = '0, alu_upd = '0;
   logic       take = 0, ret = 0, iset = 0, iclr = 0, bst = 0;
   logic [2:0] sel = '0;
   logic [7:0] opnd = '0, bld;
   logic       wr = 0;
   logic [7:0] wdat = '0;
   logic       rq_in = 0, rq_out;
   logic [7:0] sreg;
   logic       f_ie, f_cp, f_h, f_s, f_v, f_n, f_z, f_c;
   int         n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   cpu_flag_reg u_dut (
      .clk(clk), .rst_n(rst_n), .alu_val_i(alu_val), .alu_upd_i(alu_upd),
      .irq_take_i(take), .ret_irq_i(ret), .ien_set_i(iset), .ien_clr_i(iclr),
      .bit_store_i(bst), .bit_sel_i(sel), .opnd_i(opnd), .bld_o(bld),
      .wr_en_i(wr), .wr_data_i(wdat), .irq_req_i(rq_in), .irq_req_o(rq_out),
      .sreg_o(sreg), .flg_ie_o(f_ie), .flg_cp_o(f_cp), .flg_h_o(f_h),
      .flg_s_o(f_s), .flg_v_o(f_v), .flg_n_o(f_n), .flg_z_o(f_z), .flg_c_o(f_c));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      alu_upd = '0; take = 0; ret = 0; iset = 0; iclr = 0; bst = 0; wr = 0;
   endtask

   task automatic wr_word(input logic [7:0] d);
      wr = 1; wdat = d; tick();
   endtask

   task automatic t_reset();
      chk("R1 reset word", sreg, 8'h00);
      rq_in = 1; #1;
      chk("R8 gated while disabled", {7'd0, rq_out}, 8'h00);
      rq_in = 0;
   endtask

   task automatic t_write();
      wr_word(8'hFF);
      chk("R2 write all ones", sreg, 8'hEF);
      chk("R1 flag ports", {f_ie, f_cp, f_h, f_s, f_v, f_n, f_z, f_c}, 8'hEF);
      wr_word(8'h14);
      chk("R3 sign from N", sreg, 8'h14);
      wr_word(8'h10);
      chk("R2 sign bit ignored", sreg, 8'h00);
   endtask

   task automatic t_gate();
      wr_word(8'h80);
      rq_in = 1; #1;
      chk("R8 passed while enabled", {7'd0, rq_out}, 8'h01);
      rq_in = 0;
   endtask

   task automatic t_alu();
      wr_word(8'h00);
      alu_val = 5'b11111; alu_upd = 5'b00101; tick();
      chk("R4 N and C only", sreg, 8'h15);
      alu_val = 5'b00000; alu_upd = 5'b11000; tick();
      chk("R4 H V load zero", sreg, 8'h15);
      alu_val = 5'b01000; alu_upd = 5'b01000; tick();
      chk("R3 sign after V", sreg, 8'h0D);
      alu_val = 5'b10000; alu_upd = 5'b10000; tick();
      chk("R4 half carry", sreg, 8'h2D);
      alu_val = 5'b11111; alu_upd = 5'b11111; wr = 1; wdat = 8'h00; tick();
      chk("R5 write over ALU", sreg, 8'h00);
   endtask

   task automatic t_irq();
      wr_word(8'h83);
      take = 1; tick();
      chk("R11 take keeps flags", sreg, 8'h03);
      ret = 1; tick();
      chk("R11 return keeps flags", sreg, 8'h83);
      take = 1; wr = 1; wdat = 8'hC3; ret = 1; iset = 1; tick();
      chk("R6 take wins", sreg, 8'h43);
   endtask

   task automatic t_ien();
      wr_word(8'h00);
      iset = 1; tick();
      chk("R7 set", sreg, 8'h80);
      iclr = 1; tick();
      chk("R7 clear", sreg, 8'h00);
      iset = 1; iclr = 1; tick();
      chk("R7 set over clear", sreg, 8'h80);
      iclr = 1; tick();
      ret = 1; iclr = 1; tick();
      chk("R7 return over clear", sreg, 8'h80);
      iset = 1; wr = 1; wdat = 8'h00; tick();
      chk("R7 write over set", sreg, 8'h00);
   endtask

   task automatic t_copy();
      wr_word(8'h00);
      opnd = 8'h20; sel = 3'd5; bst = 1; tick();
      chk("R9 store one", sreg, 8'h40);
      sel = 3'd4; bst = 1; tick();
      chk("R9 store zero", sreg, 8'h00);
      sel = 3'd5; bst = 1; wr = 1; wdat = 8'h00; tick();
      chk("R9 write over store", sreg, 8'h00);
      wr_word(8'h40);
      opnd = 8'h00; sel = 3'd7; #1;
      chk("R10 load one at top", bld, 8'h80);
      wr_word(8'h00);
      opnd = 8'hFF; sel = 3'd0; #1;
      chk("R10 load zero at bottom", bld, 8'hFE);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1;
      #1;
      t_write();
      t_gate();
      t_alu();
      t_irq();
      t_ien();
      t_copy();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule